// File: doc/BRIEF.md
# Multi-Source Reset Controller for a Network Interface

This block turns three different reset causes into one-cycle reset strobes, one per register group of a network controller, plus the side-effect strobes that go with each cause. The three causes are:

- **Board reset.** An external active-low pin that must stay low for a minimum number of clocks.
- **Software reset.** A read access to a fixed I/O offset.
- **Stop reset.** A write that sets the stop control bit while that bit is still clear.

Each cause selects its own set of groups. Only the board reset clears the bus configuration and PCI command registers, and only it launches the serial EEPROM load. The board and software resets force the twisted-pair link unit into link fail. Every cause restarts the internal sequencer.

The block also guards the bus request line. A software reset can arrive while the request is raised. In that case the request is kept up until the arbiter grants the bus. It is dropped on the clock after the grant, and a transfer-inhibit output keeps the master from using the bus in between.

When more than one cause occurs in the same cycle, one set of strobes is emitted. It belongs to the strongest cause, in the order board, then software, then stop.

Top module: `netc_reset_ctrl`

## Requirements
- R1: `hw_rst_pin_n` passes through a two-flop synchronizer. A low pulse lasting at least MIN_PULSE clocks (default 4) produces exactly one board-reset strobe set. It appears MIN_PULSE+2 clock edges after the pin falls. A shorter pulse produces none.
- R2: An I/O read with `io_addr` equal to SW_RST_OFFSET (default 0x14) triggers a software reset. A write to that offset, or a read of any other offset, triggers nothing.
- R3: A write to CTL_OFFSET (default 0x00) with `io_wdata_stop`=1 while `stop_bit_q`=0 triggers a stop reset. The write triggers nothing if `stop_bit_q` is 1 or if `io_wdata_stop` is 0.
- R4: A board reset pulses all eight group outputs: `rst_csr_base_o`, `rst_csr_ext_o`, `rst_csr_full_o`, `rst_bcr_o`, `rst_pci_cmd_o`, `seq_rst_o`, `eeprom_load_o` and `link_fail_o`.
- R5: A software reset pulses only `rst_csr_base_o`, `rst_csr_ext_o`, `seq_rst_o` and `link_fail_o`.
- R6: A stop reset pulses only `rst_csr_base_o` and `seq_rst_o`. The link unit, the bus configuration groups and the EEPROM load are untouched.
- R7: Strobes are registered. They are high for exactly the one cycle after the clock edge that samples the triggering event, and all are low in cycles with no event.
- R8: When several causes occur in the same cycle, the group set of the highest-priority cause (board > software > stop) is emitted once. No further strobes follow for the lower-priority causes.
- R9: `bus_req_o` is `mst_req_i` OR a held request. A software reset that wins while `bus_req_o` is high and `gnt_i` is low sets the held request. The held request stays until a clock edge samples `gnt_i` high and clears on that edge. `xfer_inhibit_o` equals the held request. A board reset clears the held request.
- R10: `por_n` low clears all strobes and the held request at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset for the block's own flops, active low |
| hw_rst_pin_n | input | 1 | Board reset pin, active low, asynchronous |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_addr | input | ADDR_W | I/O offset from the base address |
| io_wdata_stop | input | 1 | Write data bit at the stop control position |
| stop_bit_q | input | 1 | Current value of the stop control bit |
| mst_req_i | input | 1 | Bus request from the master engine |
| gnt_i | input | 1 | Bus grant from the arbiter |
| rst_csr_base_o | output | 1 | Strobe: first control/status registers |
| rst_csr_ext_o | output | 1 | Strobe: extended control/status subset |
| rst_csr_full_o | output | 1 | Strobe: control/status registers cleared only by board reset |
| rst_bcr_o | output | 1 | Strobe: bus configuration registers |
| rst_pci_cmd_o | output | 1 | Strobe: PCI command register |
| seq_rst_o | output | 1 | Strobe: send internal sequencer to reset state |
| eeprom_load_o | output | 1 | Strobe: start serial EEPROM load |
| link_fail_o | output | 1 | Strobe: force link unit into link fail |
| bus_req_o | output | 1 | Bus request to the arbiter |
| xfer_inhibit_o | output | 1 | High while a held request must not start a transfer |

## Verification
Assertions check every cycle that:
- the qualified board event never fires on two consecutive cycles;
- a winning cause always produces strobes on the next cycle, and an idle cycle produces none;
- the priority order holds;
- a software reset never reaches the EEPROM or the bus configuration groups;
- a held request persists without a grant and clears after one.

The bench's scenarios cover the rest:
- the exact latency and minimum width of the pin filter;
- rejection of a short pulse;
- the asynchronous power-on clear;
- the full cycle-by-cycle sequence of a held request;
- random mixes of reads, writes, stop-bit states and grants, compared against an independent group table.

// File: rtl/netc_rst_pkg.sv
package netc_rst_pkg;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_STOP = 2'd1,
    RC_SW   = 2'd2,
    RC_HW   = 2'd3
  } rst_class_e;

  typedef struct packed {
    logic csr_base;
    logic csr_ext;
    logic csr_full;
    logic bcr;
    logic pci_cmd;
    logic seq;
    logic eeprom_load;
    logic link_fail;
  } rst_grp_t;

  // Strongest cause wins: board, then software, then stop.
  function automatic rst_class_e pick_class(logic hw, logic sw, logic stp);
    if (hw)       return RC_HW;
    else if (sw)  return RC_SW;
    else if (stp) return RC_STOP;
    else          return RC_NONE;
  endfunction

  // Group set selected by each cause.
  function automatic rst_grp_t class_groups(rst_class_e c);
    rst_grp_t g;
    g = '0;
    unique case (c)
      RC_HW: g = '1;
      RC_SW: begin
        g.csr_base  = 1'b1;
        g.csr_ext   = 1'b1;
        g.seq       = 1'b1;
        g.link_fail = 1'b1;
      end
      RC_STOP: begin
        g.csr_base = 1'b1;
        g.seq      = 1'b1;
      end
      default: g = '0;
    endcase
    return g;
  endfunction

  // Next state of the held bus request.
  function automatic logic park_next(logic park_q, logic hw_win, logic sw_win,
                                     logic req_now, logic gnt);
    if (hw_win)                       return 1'b0;
    else if (sw_win && req_now && !gnt) return 1'b1;
    else if (gnt)                     return 1'b0;
    else                              return park_q;
  endfunction

endpackage

// File: rtl/netc_rst_pin_qual.sv
module netc_rst_pin_qual #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic hw_evt_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'(MIN_PULSE - 1);
  localparam logic [CNT_W-1:0] SAT_AT  = CNT_W'(MIN_PULSE);

  logic s1_q, s2_q;
  logic pin_low;
  logic [CNT_W-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  assign pin_low = !s2_q;

  // Count consecutive low cycles, saturating so the event fires once per pulse.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 low_cnt_q <= '0;
    else if (!pin_low)          low_cnt_q <= '0;
    else if (low_cnt_q != SAT_AT) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign hw_evt_o = pin_low && (low_cnt_q == FIRE_AT);

  p_single_fire_r1: assert property (@(posedge clk) disable iff (!por_n)
    hw_evt_o |=> !hw_evt_o);

  p_fire_while_low_r1: assert property (@(posedge clk) disable iff (!por_n)
    hw_evt_o |=> (s2_q || low_cnt_q == SAT_AT));

endmodule

// File: rtl/netc_rst_arb.sv
module netc_rst_arb
  import netc_rst_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] SW_RST_OFFSET = 8'h14,
  parameter logic [ADDR_W-1:0] CTL_OFFSET    = 8'h00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_evt_i,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wdata_stop,
  input  logic              stop_bit_q,
  output logic              sw_evt_o,
  output logic              stop_evt_o,
  output rst_class_e        win_o
);
  logic sw_hit, ctl_hit;

  assign sw_hit  = (io_addr == SW_RST_OFFSET);
  assign ctl_hit = (io_addr == CTL_OFFSET);

  assign sw_evt_o   = io_rd && sw_hit;
  assign stop_evt_o = io_wr && ctl_hit && io_wdata_stop && !stop_bit_q;
  assign win_o      = pick_class(hw_evt_i, sw_evt_o, stop_evt_o);

  p_write_no_sw_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!io_rd) |-> !sw_evt_o);

  p_stop_needs_clear_r3: assert property (@(posedge clk) disable iff (!por_n)
    stop_bit_q |-> !stop_evt_o);

  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!por_n)
    hw_evt_i |-> (win_o == RC_HW));

  p_sw_over_stop_r8: assert property (@(posedge clk) disable iff (!por_n)
    (sw_evt_o && !hw_evt_i) |-> (win_o == RC_SW));

endmodule

// File: rtl/netc_rst_strobe.sv
module netc_rst_strobe
  import netc_rst_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  rst_class_e win_i,
  output rst_grp_t   grp_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) grp_o <= '0;
    else        grp_o <= class_groups(win_i);
  end

  p_strobe_next_r7: assert property (@(posedge clk) disable iff (!por_n)
    (win_i != RC_NONE) |=> (grp_o.seq && grp_o.csr_base));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!por_n)
    (win_i == RC_NONE) |=> (grp_o == '0));

  p_sw_scope_r5: assert property (@(posedge clk) disable iff (!por_n)
    (win_i == RC_SW) |=> (!grp_o.eeprom_load && !grp_o.bcr && !grp_o.pci_cmd));

  p_stop_scope_r6: assert property (@(posedge clk) disable iff (!por_n)
    (win_i == RC_STOP) |=> (!grp_o.link_fail && !grp_o.csr_ext));

  p_hw_scope_r4: assert property (@(posedge clk) disable iff (!por_n)
    (win_i == RC_HW) |=> (grp_o.eeprom_load && grp_o.bcr && grp_o.link_fail));

endmodule

// File: rtl/netc_req_park.sv
module netc_req_park
  import netc_rst_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic hw_win_i,
  input  logic sw_win_i,
  input  logic mst_req_i,
  input  logic gnt_i,
  output logic bus_req_o,
  output logic xfer_inhibit_o
);
  logic park_q;

  assign bus_req_o      = mst_req_i || park_q;
  assign xfer_inhibit_o = park_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) park_q <= 1'b0;
    else        park_q <= park_next(park_q, hw_win_i, sw_win_i, bus_req_o, gnt_i);
  end

  p_hold_until_gnt_r9: assert property (@(posedge clk) disable iff (!por_n)
    (park_q && !gnt_i && !hw_win_i) |=> park_q);

  p_drop_after_gnt_r9: assert property (@(posedge clk) disable iff (!por_n)
    (park_q && gnt_i && !sw_win_i) |=> !park_q);

  p_park_start_r9: assert property (@(posedge clk) disable iff (!por_n)
    (sw_win_i && !hw_win_i && bus_req_o && !gnt_i) |=> bus_req_o);

  p_hw_clears_r9: assert property (@(posedge clk) disable iff (!por_n)
    hw_win_i |=> !xfer_inhibit_o);

endmodule

// File: rtl/netc_reset_ctrl.sv
module netc_reset_ctrl
  import netc_rst_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] SW_RST_OFFSET = 8'h14,
  parameter logic [ADDR_W-1:0] CTL_OFFSET    = 8'h00,
  parameter int                MIN_PULSE     = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_rst_pin_n,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wdata_stop,
  input  logic              stop_bit_q,
  input  logic              mst_req_i,
  input  logic              gnt_i,
  output logic              rst_csr_base_o,
  output logic              rst_csr_ext_o,
  output logic              rst_csr_full_o,
  output logic              rst_bcr_o,
  output logic              rst_pci_cmd_o,
  output logic              seq_rst_o,
  output logic              eeprom_load_o,
  output logic              link_fail_o,
  output logic              bus_req_o,
  output logic              xfer_inhibit_o
);
  // Internal events brought out as named wires for the assertions.
  logic       hw_evt;
  logic       sw_evt;
  logic       stop_evt;
  rst_class_e win;
  rst_grp_t   grp;

  netc_rst_pin_qual #(.MIN_PULSE(MIN_PULSE)) u_pin_qual (
    .clk      (clk),
    .por_n    (por_n),
    .pin_n    (hw_rst_pin_n),
    .hw_evt_o (hw_evt)
  );

  netc_rst_arb #(
    .ADDR_W        (ADDR_W),
    .SW_RST_OFFSET (SW_RST_OFFSET),
    .CTL_OFFSET    (CTL_OFFSET)
  ) u_arb (
    .clk           (clk),
    .por_n         (por_n),
    .hw_evt_i      (hw_evt),
    .io_rd         (io_rd),
    .io_wr         (io_wr),
    .io_addr       (io_addr),
    .io_wdata_stop (io_wdata_stop),
    .stop_bit_q    (stop_bit_q),
    .sw_evt_o      (sw_evt),
    .stop_evt_o    (stop_evt),
    .win_o         (win)
  );

  netc_rst_strobe u_strobe (
    .clk   (clk),
    .por_n (por_n),
    .win_i (win),
    .grp_o (grp)
  );

  netc_req_park u_park (
    .clk            (clk),
    .por_n          (por_n),
    .hw_win_i       (win == RC_HW),
    .sw_win_i       (win == RC_SW),
    .mst_req_i      (mst_req_i),
    .gnt_i          (gnt_i),
    .bus_req_o      (bus_req_o),
    .xfer_inhibit_o (xfer_inhibit_o)
  );

  assign rst_csr_base_o = grp.csr_base;
  assign rst_csr_ext_o  = grp.csr_ext;
  assign rst_csr_full_o = grp.csr_full;
  assign rst_bcr_o      = grp.bcr;
  assign rst_pci_cmd_o  = grp.pci_cmd;
  assign seq_rst_o      = grp.seq;
  assign eeprom_load_o  = grp.eeprom_load;
  assign link_fail_o    = grp.link_fail;

  p_stop_loses_r8: assert property (@(posedge clk) disable iff (!por_n)
    (stop_evt && (sw_evt || hw_evt)) |=> !(rst_csr_base_o && !rst_csr_ext_o));

  p_eeprom_board_only_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_evt) |=> !eeprom_load_o);

endmodule

// File: tb/netc_reset_ctrl_tb.sv
module netc_reset_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_PULSE  = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic hw_rst_pin_n = 1'b1;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic io_wdata_stop = 1'b0, stop_bit_q = 1'b0;
  logic mst_req_i = 1'b0, gnt_i = 1'b0;
  logic rst_csr_base_o, rst_csr_ext_o, rst_csr_full_o, rst_bcr_o, rst_pci_cmd_o;
  logic seq_rst_o, eeprom_load_o, link_fail_o, bus_req_o, xfer_inhibit_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_grp = 8'h00;
  logic park_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  netc_reset_ctrl #(.MIN_PULSE(MIN_PULSE)) u_dut (.*);

  function automatic logic [7:0] got_grp();
    return {rst_csr_base_o, rst_csr_ext_o, rst_csr_full_o, rst_bcr_o,
            rst_pci_cmd_o, seq_rst_o, eeprom_load_o, link_fail_o};
  endfunction

  // cls: 0 none, 1 stop, 2 software, 3 board (bit order as got_grp)
  function automatic logic [7:0] exp_groups(int cls);
    logic [7:0] v = 8'h00;
    if (cls == 3) return 8'hFF;
    if (cls >= 1) begin v[7] = 1'b1; v[2] = 1'b1; end
    if (cls == 2) begin v[6] = 1'b1; v[0] = 1'b1; end
    return v;
  endfunction

  function automatic int exp_class(logic rd, logic wr, logic [7:0] a,
                                   logic wd, logic sq);
    if (rd && a == 8'h14) return 2;
    if (wr && a == 8'h00 && wd && !sq) return 1;
    return 0;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one cycle at a negedge, check combinational request, then the
  // registered results at the following negedge.
  task automatic step(string req, logic rd, logic wr, logic [7:0] a,
                      logic wd, logic sq, logic mr, logic g);
    int cls;
    logic req_now;
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata_stop = wd;
    stop_bit_q = sq; mst_req_i = mr; gnt_i = g;
    #1;
    req_now = mr | park_m;
    chk({req, " bus_req"}, {7'd0, bus_req_o}, {7'd0, req_now});
    cls = exp_class(rd, wr, a, wd, sq);
    exp_grp = exp_groups(cls);
    if (cls == 2 && req_now && !g) park_m = 1'b1;
    else if (g) park_m = 1'b0;
    @(negedge clk);
    chk({req, " groups"}, got_grp(), exp_grp);
    chk({req, " inhibit"}, {7'd0, xfer_inhibit_o}, {7'd0, park_m});
  endtask

  task automatic idle_inputs();
    io_rd = 0; io_wr = 0; io_addr = 8'h00; io_wdata_stop = 0;
    stop_bit_q = 0; mst_req_i = 0; gnt_i = 0;
  endtask

  // Board pulse of len cycles; count strobe sets and their position.
  task automatic pulse(int len, int exp_hits);
    int hits = 0;
    int at = -1;
    idle_inputs();
    @(negedge clk);
    hw_rst_pin_n = 1'b0;
    for (int i = 1; i <= MIN_PULSE + 10; i++) begin
      @(negedge clk);
      if (i == len) hw_rst_pin_n = 1'b1;
      if (got_grp() != 8'h00) begin
        hits++;
        at = i;
        chk("R4 board groups", got_grp(), 8'hFF);
      end
    end
    hw_rst_pin_n = 1'b1;
    chk("R1 pulse count", 8'(hits), 8'(exp_hits));
    if (exp_hits == 1) chk("R1 latency", 8'(at), 8'(MIN_PULSE + 2));
    park_m = 1'b0;
    exp_grp = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset groups", got_grp(), 8'h00);
    chk("R10 reset inhibit", {7'd0, xfer_inhibit_o}, 8'h00);
    por_n = 1'b1;
    @(negedge clk);

    // R2 software reset decode
    step("R2 R5 sw read", 1, 0, 8'h14, 0, 0, 0, 0);
    step("R2 write to sw offset", 0, 1, 8'h14, 1, 0, 0, 0);
    step("R2 read other offset", 1, 0, 8'h10, 0, 0, 0, 0);
    // R3 R6 stop reset
    step("R3 R6 stop 0to1", 0, 1, 8'h00, 1, 0, 0, 0);
    step("R3 stop already set", 0, 1, 8'h00, 1, 1, 0, 0);
    step("R3 stop data zero", 0, 1, 8'h00, 0, 0, 0, 0);
    step("R3 stop read", 1, 0, 8'h00, 1, 0, 0, 0);
    // R7 back-to-back then quiet
    step("R7 first", 1, 0, 8'h14, 0, 0, 0, 0);
    step("R7 second", 1, 0, 8'h14, 0, 0, 0, 0);
    step("R7 quiet", 0, 0, 8'h00, 0, 0, 0, 0);
    // R8 software over stop in one cycle
    step("R8 sw and stop", 1, 0, 8'h14, 1, 0, 0, 0);
    step("R8 no late stop", 0, 0, 8'h00, 0, 0, 0, 0);

    // R9 held request
    step("R9 master req", 0, 0, 8'h00, 0, 0, 1, 0);
    step("R9 sw with req", 1, 0, 8'h14, 0, 0, 1, 0);
    step("R9 hold 1", 0, 0, 8'h00, 0, 0, 0, 0);
    step("R9 hold 2", 0, 0, 8'h00, 0, 0, 0, 0);
    step("R9 grant", 0, 0, 8'h00, 0, 0, 0, 1);
    step("R9 dropped", 0, 0, 8'h00, 0, 0, 0, 0);
    step("R9 sw no req", 1, 0, 8'h14, 0, 0, 0, 0);
    step("R9 sw with grant", 1, 0, 8'h14, 0, 0, 1, 1);
    step("R9 after grant", 0, 0, 8'h00, 0, 0, 0, 0);

    // R1 R4 board pin
    pulse(MIN_PULSE, 1);
    pulse(MIN_PULSE + 3, 1);
    pulse(MIN_PULSE - 1, 0);

    // R8 board over software and stop in the same cycle
    idle_inputs();
    @(negedge clk);
    hw_rst_pin_n = 1'b0;
    repeat (MIN_PULSE + 1) @(negedge clk);
    io_rd = 1; io_addr = 8'h14;
    @(negedge clk);
    io_rd = 0;
    chk("R8 board wins", got_grp(), 8'hFF);
    @(negedge clk);
    chk("R8 merged no extra", got_grp(), 8'h00);
    hw_rst_pin_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 board reset clears held request
    step("R9 req again", 0, 0, 8'h00, 0, 0, 1, 0);
    step("R9 park again", 1, 0, 8'h14, 0, 0, 1, 0);
    idle_inputs();
    hw_rst_pin_n = 1'b0;
    repeat (MIN_PULSE + 3) @(negedge clk);
    chk("R9 board clears hold", {7'd0, xfer_inhibit_o}, 8'h00);
    hw_rst_pin_n = 1'b1;
    park_m = 1'b0;
    repeat (4) @(negedge clk);

    // Random mix, R2 R3 R5 R6 R7 R9
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 8'h14 : (sel == 1) ? 8'h00 : 8'($urandom_range(0, 255));
      step("R5 R6 R9 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0));
    end

    // R10 asynchronous clear mid-run
    step("R10 setup req", 0, 0, 8'h00, 0, 0, 1, 0);
    step("R10 setup park", 1, 0, 8'h14, 0, 0, 1, 0);
    #2;
    por_n = 1'b0;
    #1;
    chk("R10 async inhibit", {7'd0, xfer_inhibit_o}, 8'h00);
    chk("R10 async groups", got_grp(), 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule